// File: doc/BRIEF.md
# Mode-Selected Floating-Point Rounding Stage

This block is the last step of a floating-point datapath. Upstream logic has already normalised the result and packed it into a sign bit and an exponent:mantissa word with the hidden bit dropped. It has also produced a guard bit and a sticky bit. The stage decides whether to add one unit in the last place, and it uses a rounding-mode code to make that decision. It delivers the final packed word together with inexact and overflow flags.

The decision is a lookup. Each of the five rounding modes owns a 16-entry, one-bit table. The table is indexed by the sign bit, the current ulp bit (bit 0 of the packed word), the guard bit and the sticky bit. The selected bit is added at bit 0 of the whole exponent:mantissa word. A mantissa that rolls over from all ones to zero therefore carries straight into the exponent, and it can land on the infinity encoding. Binary32 is the default format: 8 exponent bits and 23 mantissa bits. The outputs are registered by default. The register can be removed with a parameter.

Top module: `fpr_round`

## Requirements
- R1: Mode code 0 (nearest, ties to even) adds one exactly when guard is 1 and either sticky or the ulp bit (bit 0 of the packed word) is 1.
- R2: Mode code 1 (toward +infinity) adds one exactly when the sign is 0 and guard or sticky is 1.
- R3: Mode code 2 (toward -infinity) adds one exactly when the sign is 1 and guard or sticky is 1.
- R4: Mode code 3 (toward zero) never adds. The packed word leaves unchanged.
- R5: Mode code 4 (nearest, ties away from zero) adds one exactly when guard is 1.
- R6: Mode codes 5, 6 and 7 behave exactly as mode code 0.
- R7: The increment is added at bit 0 of the packed exponent:mantissa word. A mantissa of all ones therefore becomes all zeros, and the exponent field goes up by one.
- R8: The overflow output is 1 exactly when the exponent field of the rounded word is all ones. When rounding carries a finite input into that field, the mantissa of the result is all zeros (the infinity encoding).
- R9: The inexact output is 1 whenever guard or sticky is 1, whether or not an increment took place. Otherwise it is 0.
- R10: The sign output equals the sign input.
- R11: With OUT_REG=1, each result appears on the outputs at the first rising clock edge after its inputs. A synchronous active-high reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| sign_i | input | 1 | Sign of the unrounded result |
| em_i | input | EXP_W+MAN_W | Packed exponent:mantissa, hidden bit removed |
| guard_i | input | 1 | First bit below the ulp |
| sticky_i | input | 1 | OR of all bits below guard |
| mode_i | input | 3 | Rounding-mode code (0..4, 5..7 as 0) |
| sign_o | output | 1 | Sign of the rounded result |
| em_o | output | EXP_W+MAN_W | Rounded packed exponent:mantissa |
| inexact_o | output | 1 | Guard or sticky was set |
| overflow_o | output | 1 | Rounded exponent field is all ones |

## Verification
Two functions can fall in the same cycle. One is the round-up increment carrying across the mantissa into the exponent. The other is the overflow flag, which that same carry raises. The bench provokes both by feeding the largest finite binary32 magnitude with guard set under a round-up mode. It expects the exact infinity word, overflow high and inexact high, all on one edge. The same input under round-toward-zero must leave the word untouched with overflow low. A sweep over all eight mode codes and all sixteen sign/ulp/guard/sticky combinations compares each increment with a model derived from the requirements.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  localparam int NUM_MODES = 5;
  localparam int IDX_W     = 4;
  localparam int TBL_LEN   = 1 << IDX_W;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_POS_INF   = 3'd1,
    RM_NEG_INF   = 3'd2,
    RM_ZERO      = 3'd3,
    RM_NEAR_AWAY = 3'd4
  } rmode_e;

  // Table entry index layout: {sign, ulp, guard, sticky}
  function automatic logic [TBL_LEN-1:0] build_table(input int mode);
    logic [TBL_LEN-1:0] t;
    logic s, u, g, k;
    t = '0;
    for (int i = 0; i < TBL_LEN; i++) begin
      s = i[3];
      u = i[2];
      g = i[1];
      k = i[0];
      case (mode)
        1:       t[i] = !s && (g || k);
        2:       t[i] = s && (g || k);
        3:       t[i] = 1'b0;
        4:       t[i] = g;
        default: t[i] = g && (k || u);
      endcase
    end
    return t;
  endfunction

endpackage

// File: rtl/fpr_table.sv
module fpr_table
  import fpr_pkg::*;
(
  input  logic       sign_i,
  input  logic       ulp_i,
  input  logic       guard_i,
  input  logic       sticky_i,
  input  logic [2:0] mode_i,
  output logic       inc_o
);

  logic [TBL_LEN-1:0] tbl [NUM_MODES];
  logic [IDX_W-1:0]   idx;
  logic [2:0]         sel;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_tbl
    assign tbl[m] = build_table(m);
  end

  assign idx = {sign_i, ulp_i, guard_i, sticky_i};

  // Unassigned mode codes fall back to nearest-even
  always_comb begin
    if (mode_i < 3'(NUM_MODES)) sel = mode_i;
    else                        sel = RM_NEAR_EVEN;
  end

  assign inc_o = tbl[sel][idx];

endmodule

// File: rtl/fpr_incr.sv
module fpr_incr #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = EXP_W + MAN_W
) (
  input  logic [W-1:0] em_i,
  input  logic         inc_i,
  input  logic         guard_i,
  input  logic         sticky_i,
  output logic [W-1:0] em_o,
  output logic         inexact_o,
  output logic         overflow_o
);

  // Add across the whole word so mantissa carry lands in the exponent
  assign em_o       = em_i + W'(inc_i);
  assign overflow_o = &em_o[W-1:MAN_W];
  assign inexact_o  = guard_i | sticky_i;

endmodule

// File: rtl/fpr_round.sv
module fpr_round #(
  parameter int EXP_W   = 8,
  parameter int MAN_W   = 23,
  parameter bit OUT_REG = 1'b1,
  localparam int W = EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sign_i,
  input  logic [W-1:0] em_i,
  input  logic         guard_i,
  input  logic         sticky_i,
  input  logic [2:0]   mode_i,
  output logic         sign_o,
  output logic [W-1:0] em_o,
  output logic         inexact_o,
  output logic         overflow_o
);

  logic         inc;
  logic [W-1:0] em_r;
  logic         inx_r;
  logic         ovf_r;

  fpr_table u_table (
    .sign_i   (sign_i),
    .ulp_i    (em_i[0]),
    .guard_i  (guard_i),
    .sticky_i (sticky_i),
    .mode_i   (mode_i),
    .inc_o    (inc)
  );

  fpr_incr #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_incr (
    .em_i       (em_i),
    .inc_i      (inc),
    .guard_i    (guard_i),
    .sticky_i   (sticky_i),
    .em_o       (em_r),
    .inexact_o  (inx_r),
    .overflow_o (ovf_r)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sign_o     <= 1'b0;
        em_o       <= '0;
        inexact_o  <= 1'b0;
        overflow_o <= 1'b0;
      end else begin
        sign_o     <= sign_i;
        em_o       <= em_r;
        inexact_o  <= inx_r;
        overflow_o <= ovf_r;
      end
    end

    AST_SIGN_PASS: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> sign_o == $past(sign_i)); // R10

    AST_ZERO_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
      mode_i == 3'd3 |=> em_o == $past(em_i)); // R4

    AST_INEXACT: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> inexact_o == ($past(guard_i) || $past(sticky_i))); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (em_o == $past(em_i)) || (em_o == $past(em_i) + W'(1))); // R7

    AST_OVF_TO_INF: assert property (@(posedge clk) disable iff (rst)
      !(&em_i[W-1:MAN_W]) |=> !overflow_o || (em_o[MAN_W-1:0] == '0)); // R8

    AST_EXACT_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
      (!guard_i && !sticky_i) |=> em_o == $past(em_i)); // R1
  end else begin : g_comb
    assign sign_o     = sign_i;
    assign em_o       = em_r;
    assign inexact_o  = inx_r;
    assign overflow_o = ovf_r;
  end

endmodule

// File: tb/fpr_round_tb.sv
module fpr_round_tb;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int W = EXP_W + MAN_W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sign_i = 1'b0;
  logic [W-1:0] em_i = '0;
  logic         guard_i = 1'b0;
  logic         sticky_i = 1'b0;
  logic [2:0]   mode_i = 3'd0;
  logic         sign_o;
  logic [W-1:0] em_o;
  logic         inexact_o;
  logic         overflow_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpr_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .sign_i(sign_i), .em_i(em_i),
    .guard_i(guard_i), .sticky_i(sticky_i), .mode_i(mode_i),
    .sign_o(sign_o), .em_o(em_o), .inexact_o(inexact_o),
    .overflow_o(overflow_o)
  );

  function automatic bit model_inc(input logic [2:0] m, input bit s,
                                   input bit u, input bit g, input bit k);
    case (m)
      3'd1:    return !s && (g || k);
      3'd2:    return s && (g || k);
      3'd3:    return 1'b0;
      3'd4:    return g;
      default: return g && (k || u);
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive at negedge, result visible after the next posedge (sampled at negedge)
  task automatic run(input string req, input bit s, input logic [W-1:0] em,
                     input bit g, input bit k, input logic [2:0] m,
                     input logic [W-1:0] exp_em, input bit exp_ovf);
    logic [W-1:0] prev;
    @(negedge clk);
    prev = em_o;
    sign_i = s; em_i = em; guard_i = g; sticky_i = k; mode_i = m;
    #1;
    check({req, " R11 hold before edge"}, em_o, prev);
    @(negedge clk);
    check(req, em_o, exp_em);
    check({req, " R10 sign"}, W'(sign_o), W'(s));
    check({req, " R9 inexact"}, W'(inexact_o), W'(g | k));
    check({req, " R8 overflow"}, W'(overflow_o), W'(exp_ovf));
  endtask

  localparam logic [W-1:0] ONE_E  = 31'h3F80_0000;
  localparam logic [W-1:0] ONE_O  = 31'h3F80_0001;
  localparam logic [W-1:0] MAXF   = 31'h7F7F_FFFF;
  localparam logic [W-1:0] INF    = 31'h7F80_0000;

  task automatic t_reset();
    @(negedge clk);
    check("R11 reset em", em_o, '0);
    check("R11 reset flags", W'({sign_o, inexact_o, overflow_o}), '0);
  endtask

  task automatic t_near_even();
    run("R1 tie ulp0", 0, ONE_E, 1, 0, 3'd0, ONE_E, 0);
    run("R1 tie ulp1", 0, ONE_O, 1, 0, 3'd0, ONE_O + 1, 0);
    run("R1 above half", 1, ONE_E, 1, 1, 3'd0, ONE_E + 1, 0);
    run("R1 below half", 0, ONE_O, 0, 1, 3'd0, ONE_O, 0);
  endtask

  task automatic t_directed();
    run("R2 pos up", 0, ONE_E, 0, 1, 3'd1, ONE_E + 1, 0);
    run("R2 neg stays", 1, ONE_E, 1, 1, 3'd1, ONE_E, 0);
    run("R3 neg up", 1, ONE_E, 0, 1, 3'd2, ONE_E + 1, 0);
    run("R3 pos stays", 0, ONE_E, 1, 0, 3'd2, ONE_E, 0);
    run("R4 zero mode", 0, ONE_O, 1, 1, 3'd3, ONE_O, 0);
    run("R5 away tie", 1, ONE_E, 1, 0, 3'd4, ONE_E + 1, 0);
    run("R5 away below", 0, ONE_E, 0, 1, 3'd4, ONE_E, 0);
    run("R9 exact", 0, ONE_O, 0, 0, 3'd1, ONE_O, 0);
  endtask

  task automatic t_alias();
    for (int m = 5; m < 8; m++) begin
      run("R6 alias tie ulp1", 0, ONE_O, 1, 0, 3'(m), ONE_O + 1, 0);
      run("R6 alias tie ulp0", 0, ONE_E, 1, 0, 3'(m), ONE_E, 0);
    end
  endtask

  task automatic t_carry();
    run("R7 mantissa rollover", 0, 31'h3F7F_FFFF, 1, 1, 3'd0, ONE_E, 0);
    run("R8 overflow to inf", 0, MAXF, 1, 0, 3'd1, INF, 1);
    run("R8 no overflow rtz", 0, MAXF, 1, 0, 3'd3, MAXF, 0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 16; i++) begin
        logic [W-1:0] base;
        bit inc;
        base = i[2] ? 31'h4000_1235 : 31'h4000_1234;
        inc  = model_inc(3'(m), i[3], i[2], i[1], i[0]);
        run("R1 R2 R3 R4 R5 R6 sweep", i[3], base, i[1], i[0], 3'(m),
            base + W'(inc), 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_near_even();
    t_directed();
    t_alias();
    t_carry();
    t_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule